// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-visible side of an SMBus host controller. Software programs a target address, a command byte and up to two data bytes through a byte-wide register port. It can also load a 32-byte block buffer through a single auto-incrementing data port. Software then writes the control register with the start bit set. The block decodes the protocol field and issues exactly one transaction request, one cycle wide, to a bus engine. The request carries everything the engine needs: the protocol code, the direction, the 7-bit target, the command, both data bytes and the whole block buffer.

When the engine reports completion, the block writes the returned bytes into the data registers or the block buffer, as the latched protocol and direction require. It then drops busy and raises done, which also drives the interrupt line. A protocol code that is not supported sets an error flag and issues nothing. The bit-level bus engine is outside this block.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, the status, control, command, address, data0 and data1 registers all read 0, the interrupt is low and no request is issued.
- R2: The command (offset 3), address (offset 4), data0 (offset 5) and data1 (offset 6) registers read back the last value written. Control (offset 2) reads back only its bits 4:0, with bits 7:5 read as 0. Offset 1 reads 0.
- R3: A control write with bit 6 (start) set and a protocol field in bits 4:2 of 0 (quick), 1 (byte), 2 (byte-data), 3 (word-data) or 5 (block) sets status bit 0 (busy). In the next cycle it raises reqValid for exactly one cycle. That cycle carries the protocol code, reqRead = address bit 0, reqTarget = address bits 7:1, and the command, data0 and data1 registers.
- R4: A start with protocol code 4, 6 or 7 issues no request, leaves busy clear and sets status bit 2 (error).
- R5: While busy is set, control writes are ignored: they issue no second request and do not change the control readback.
- R6: rspValid while busy clears busy and sets status bit 1 (done), and irq follows done. rspValid while not busy changes nothing.
- R7: On completion of a byte or byte-data read, data0 takes rspData0 and data1 is unchanged. Completion of any write leaves data0 and data1 unchanged.
- R8: On completion of a word-data read, data0 takes rspData0 (low byte) and data1 takes rspData1 (high byte).
- R9: On completion of a block read, data0 takes the returned count (rspData0), and the buffer takes rspBlock, with entry i in bits 8i+7:8i.
- R10: Each read or write of the block port (offset 7) accesses the buffer entry at the current index and then increments the index, which wraps from 31 to 0. Reads and writes share the index, and an accepted start resets it to 0.
- R11: Status bits 0, 1 and 2 are write-1-to-clear. A written 0 leaves the bit unchanged.
- R12: A block write request carries the byte count in reqData0 and the buffer on reqBlock, with entry i in bits 8i+7:8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 3 | Register offset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (advances the block index on offset 7) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regSel, combinational |
| irq | output | 1 | Completion interrupt (status done) |
| reqValid | output | 1 | One-cycle transaction request |
| reqProto | output | 3 | Protocol code of the request |
| reqRead | output | 1 | 1 = read, 0 = write |
| reqTarget | output | 7 | 7-bit target address |
| reqCmd | output | 8 | Command byte |
| reqData0 | output | 8 | Data0 (byte count for block) |
| reqData1 | output | 8 | Data1 |
| reqBlock | output | 256 | Block buffer contents |
| rspValid | input | 1 | Engine completion strobe |
| rspData0 | input | 8 | Returned low byte or block count |
| rspData1 | input | 8 | Returned high byte |
| rspBlock | input | 256 | Returned block bytes |

## Verification
The bench goes after the block-port index. It writes 33 bytes, so a design that does not wrap would lose the last byte or write past the buffer, and the first entry seen on the block request would be stale. After a block read it walks the index across 31 and checks that the next read returns entry 0 again. This also exposes a design that fails to reset the index on start, which would return bytes from the wrong place. A second start sent while busy catches a design that issues a duplicate request or lets the protocol change under an in-flight transfer. An unsupported code catches a design that requests anyway. Byte-read and write completions catch a design that clobbers data1 or overwrites data registers on writes.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3,
    PR_RSV4  = 3'd4,
    PR_BLOCK = 3'd5,
    PR_RSV6  = 3'd6,
    PR_RSV7  = 3'd7
  } proto_e;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_ADR  = 3'd4;
  localparam logic [2:0] OFS_D0   = 3'd5;
  localparam logic [2:0] OFS_D1   = 3'd6;
  localparam logic [2:0] OFS_BLK  = 3'd7;

  localparam int START_BIT = 6;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrCtl;
    logic wrCmd;
    logic wrAdr;
    logic wrD0;
    logic wrD1;
    logic wrBlk;
    logic rdBlk;
    logic start;
    logic rspLoad;
  } strobe_t;

  function automatic logic protoSupported(input logic [2:0] code);
    return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
           (code == PR_WORD)  || (code == PR_BLOCK);
  endfunction

endpackage

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
  import smb_host_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          startBit,
  input  logic [2:0]    protoIn,
  input  logic [2:0]    clrBits,
  input  logic          rspValid,
  output strobe_t       stb,
  output logic [7:0]    statusByte,
  output logic          reqPulse
);

  logic busyQ, doneQ, errQ;
  logic wrCtlOk, startOk, startBad, rspTake;
  logic [2:0] w1c;

  always_comb begin
    wrCtlOk  = wrEn && (regSel == OFS_CTL) && !busyQ;
    startOk  = wrCtlOk && startBit && protoSupported(protoIn);
    startBad = wrCtlOk && startBit && !protoSupported(protoIn);
    rspTake  = rspValid && busyQ;
    w1c      = (wrEn && (regSel == OFS_STAT)) ? clrBits : 3'b000;

    stb.wrCtl   = wrCtlOk;
    stb.wrCmd   = wrEn && (regSel == OFS_CMD);
    stb.wrAdr   = wrEn && (regSel == OFS_ADR);
    stb.wrD0    = wrEn && (regSel == OFS_D0);
    stb.wrD1    = wrEn && (regSel == OFS_D1);
    stb.wrBlk   = wrEn && (regSel == OFS_BLK);
    stb.rdBlk   = rdEn && (regSel == OFS_BLK);
    stb.start   = startOk;
    stb.rspLoad = rspTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
      reqPulse <= 1'b0;
    end else begin
      reqPulse <= startOk;

      if (startOk)      busyQ <= 1'b1;
      else if (rspTake) busyQ <= 1'b0;
      else if (w1c[0])  busyQ <= 1'b0;

      if (rspTake)      doneQ <= 1'b1;
      else if (w1c[1])  doneQ <= 1'b0;

      if (startBad)     errQ <= 1'b1;
      else if (w1c[2])  errQ <= 1'b0;
    end
  end

  assign statusByte = {5'b00000, errQ, doneQ, busyQ};

endmodule

// File: rtl/smb_host_data.sv
module smb_host_data
  import smb_host_pkg::*;
#(
  parameter int BLK_DEPTH = 32,
  localparam int IDX_W    = $clog2(BLK_DEPTH),
  localparam int BLK_BITS = BLK_DEPTH * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [2:0]          regSel,
  input  logic [7:0]          wrData,
  input  logic [7:0]          statusByte,
  input  logic [7:0]          rspData0,
  input  logic [7:0]          rspData1,
  input  logic [BLK_BITS-1:0] rspBlock,
  output logic [7:0]          rdData,
  output logic [2:0]          reqProto,
  output logic                reqRead,
  output logic [6:0]          reqTarget,
  output logic [7:0]          reqCmd,
  output logic [7:0]          reqData0,
  output logic [7:0]          reqData1,
  output logic [BLK_BITS-1:0] reqBlock,
  output logic [IDX_W-1:0]    blkIdx
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_DEPTH - 1);

  logic [4:0]  ctlReg;
  logic [7:0]  cmdReg, adrReg, d0Reg, d1Reg;
  logic [2:0]  xferProto;
  logic        xferRead;
  logic [7:0]  blkMem [BLK_DEPTH];
  logic        blkFill;

  assign blkFill = stb.rspLoad && xferRead && (xferProto == PR_BLOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg    <= '0;
      cmdReg    <= '0;
      adrReg    <= '0;
      xferProto <= '0;
      xferRead  <= 1'b0;
    end else begin
      if (stb.wrCtl) ctlReg <= wrData[4:0];
      if (stb.wrCmd) cmdReg <= wrData;
      if (stb.wrAdr) adrReg <= wrData;
      if (stb.start) begin
        xferProto <= wrData[4:2];
        xferRead  <= adrReg[0];
      end
    end
  end

  // Data registers: software writes, engine returns on read completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      d0Reg <= '0;
      d1Reg <= '0;
    end else if (stb.rspLoad && xferRead) begin
      unique case (xferProto)
        PR_BYTE, PR_BDATA, PR_BLOCK: d0Reg <= rspData0;
        PR_WORD: begin
          d0Reg <= rspData0;
          d1Reg <= rspData1;
        end
        default: ;
      endcase
    end else begin
      if (stb.wrD0) d0Reg <= wrData;
      if (stb.wrD1) d1Reg <= wrData;
    end
  end

  // Block index: shared by port reads and writes, cleared on start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkIdx <= '0;
    end else if (stb.start) begin
      blkIdx <= '0;
    end else if (stb.wrBlk || stb.rdBlk) begin
      blkIdx <= (blkIdx == IDX_LAST) ? '0 : blkIdx + 1'b1;
    end
  end

  for (genvar i = 0; i < BLK_DEPTH; i++) begin : g_blk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blkMem[i] <= '0;
      end else if (blkFill) begin
        blkMem[i] <= rspBlock[i*8 +: 8];
      end else if (stb.wrBlk && (blkIdx == IDX_W'(i))) begin
        blkMem[i] <= wrData;
      end
    end
    assign reqBlock[i*8 +: 8] = blkMem[i];
  end

  always_comb begin
    unique case (regSel)
      OFS_STAT: rdData = statusByte;
      OFS_CTL:  rdData = {3'b000, ctlReg};
      OFS_CMD:  rdData = cmdReg;
      OFS_ADR:  rdData = adrReg;
      OFS_D0:   rdData = d0Reg;
      OFS_D1:   rdData = d1Reg;
      OFS_BLK:  rdData = blkMem[blkIdx];
      default:  rdData = 8'h00;
    endcase
  end

  assign reqProto  = xferProto;
  assign reqRead   = adrReg[0];
  assign reqTarget = adrReg[7:1];
  assign reqCmd    = cmdReg;
  assign reqData0  = d0Reg;
  assign reqData1  = d1Reg;

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int BLK_DEPTH = 32,
  localparam int IDX_W    = $clog2(BLK_DEPTH),
  localparam int BLK_BITS = BLK_DEPTH * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  output logic                irq,
  output logic                reqValid,
  output logic [2:0]          reqProto,
  output logic                reqRead,
  output logic [6:0]          reqTarget,
  output logic [7:0]          reqCmd,
  output logic [7:0]          reqData0,
  output logic [7:0]          reqData1,
  output logic [BLK_BITS-1:0] reqBlock,
  input  logic                rspValid,
  input  logic [7:0]          rspData0,
  input  logic [7:0]          rspData1,
  input  logic [BLK_BITS-1:0] rspBlock
);

  strobe_t          stb;
  logic [7:0]       statusByte;
  logic [IDX_W-1:0] blkIdx;

  smb_host_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .startBit   (wrData[START_BIT]),
    .protoIn    (wrData[4:2]),
    .clrBits    (wrData[2:0]),
    .rspValid   (rspValid),
    .stb        (stb),
    .statusByte (statusByte),
    .reqPulse   (reqValid)
  );

  smb_host_data #(.BLK_DEPTH(BLK_DEPTH)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regSel     (regSel),
    .wrData     (wrData),
    .statusByte (statusByte),
    .rspData0   (rspData0),
    .rspData1   (rspData1),
    .rspBlock   (rspBlock),
    .rdData     (rdData),
    .reqProto   (reqProto),
    .reqRead    (reqRead),
    .reqTarget  (reqTarget),
    .reqCmd     (reqCmd),
    .reqData0   (reqData0),
    .reqData1   (reqData1),
    .reqBlock   (reqBlock),
    .blkIdx     (blkIdx)
  );

  assign irq = statusByte[1];

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int BLK_DEPTH = 32,
  localparam int IDX_W    = $clog2(BLK_DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       regSel,
  input logic             wrEn,
  input logic             rdEn,
  input logic [7:0]       wrData,
  input logic             reqValid,
  input logic [2:0]       reqProto,
  input logic             rspValid,
  input logic [7:0]       statusByte,
  input logic [IDX_W-1:0] blkIdx
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_DEPTH - 1);

  // R3: request is a single-cycle pulse
  a_r3_req_single: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R3: a request is only seen while busy
  a_r3_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> statusByte[0]);

  // R3: only supported codes reach the engine
  a_r3_proto_legal: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqProto inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5}));

  // R4: unsupported start issues nothing and flags error
  a_r4_bad_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd2 && wrData[6] && !statusByte[0] &&
     (wrData[4:2] inside {3'd4, 3'd6, 3'd7}))
    |=> (!reqValid && statusByte[2] && !statusByte[0]));

  // R5: no request follows a busy cycle
  a_r5_no_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !reqValid) |=> !reqValid);

  // R6: completion clears busy and sets done
  a_r6_complete: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && statusByte[0]) |=> (statusByte[1] && !statusByte[0]));

  // R10: index wraps after the last entry
  a_r10_idx_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd7 && (wrEn || rdEn) && blkIdx == IDX_LAST) |=> (blkIdx == '0));

endmodule

bind smb_host_regs smb_host_regs_chk #(.BLK_DEPTH(BLK_DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .wrData     (wrData),
  .reqValid   (reqValid),
  .reqProto   (reqProto),
  .rspValid   (rspValid),
  .statusByte (statusByte),
  .blkIdx     (blkIdx)
);

// File: tb/tb_smb_host_regs.sv
module tb_smb_host_regs;

  localparam int BLK_BITS = 256;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [2:0]          regSel = '0;
  logic                wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]          wrData = '0;
  logic [7:0]          rdData;
  logic                irq, reqValid, reqRead;
  logic [2:0]          reqProto;
  logic [6:0]          reqTarget;
  logic [7:0]          reqCmd, reqData0, reqData1;
  logic [BLK_BITS-1:0] reqBlock;
  logic                rspValid = 1'b0;
  logic [7:0]          rspData0 = '0, rspData1 = '0;
  logic [BLK_BITS-1:0] rspBlock = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]          proto;
    logic                rd;
    logic [6:0]          tgt;
    logic [7:0]          cmd, d0, d1;
    bit                  chkBlk;
    logic [BLK_BITS-1:0] blk;
  } item_t;

  item_t expQ[$];

  always #4 clk = ~clk;

  smb_host_regs dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .reqValid(reqValid),
    .reqProto(reqProto), .reqRead(reqRead), .reqTarget(reqTarget),
    .reqCmd(reqCmd), .reqData0(reqData0), .reqData1(reqData1),
    .reqBlock(reqBlock), .rspValid(rspValid), .rspData0(rspData0),
    .rspData1(rspData1), .rspBlock(rspBlock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    regSel = s; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    regSel = s; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic start(input logic [2:0] p, input item_t it);
    expQ.push_back(it);
    wr(3'd2, 8'h40 | {3'b000, p, 2'b00});
  endtask

  task automatic complete(input logic [7:0] a, input logic [7:0] b,
                          input logic [BLK_BITS-1:0] blk);
    @(negedge clk);
    rspValid = 1'b1; rspData0 = a; rspData1 = b; rspBlock = blk;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  // Monitor: pops expected requests as the design issues them
  always @(negedge clk) begin
    if (rstN && reqValid) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected request", {29'd0, reqProto}, 32'hFFFF_FFFF);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk("R3 proto", {29'd0, reqProto}, {29'd0, e.proto});
        chk("R3 read", {31'd0, reqRead}, {31'd0, e.rd});
        chk("R3 target", {25'd0, reqTarget}, {25'd0, e.tgt});
        chk("R3 cmd", {24'd0, reqCmd}, {24'd0, e.cmd});
        chk("R3 data0", {24'd0, reqData0}, {24'd0, e.d0});
        chk("R3 data1", {24'd0, reqData1}, {24'd0, e.d1});
        if (e.chkBlk) begin
          for (int i = 0; i < 32; i++)
            chk("R12 block entry", {24'd0, reqBlock[i*8 +: 8]}, {24'd0, e.blk[i*8 +: 8]});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    item_t it;
    logic [BLK_BITS-1:0] blkExp, blkRsp;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 status", {24'd0, v}, 0);
    rd(3'd2, v); chk("R1 control", {24'd0, v}, 0);
    rd(3'd5, v); chk("R1 data0", {24'd0, v}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 readback
    wr(3'd3, 8'h5A); rd(3'd3, v); chk("R2 cmd", {24'd0, v}, 32'h5A);
    wr(3'd6, 8'hC3); rd(3'd6, v); chk("R2 data1", {24'd0, v}, 32'hC3);
    wr(3'd5, 8'h96); rd(3'd5, v); chk("R2 data0", {24'd0, v}, 32'h96);
    wr(3'd2, 8'hBF); rd(3'd2, v); chk("R2 control low bits", {24'd0, v}, 32'h1F);
    rd(3'd1, v); chk("R2 offset1", {24'd0, v}, 0);

    // R3 quick write, R5 start while busy
    wr(3'd4, 8'hA0);
    it = '{proto:3'd0, rd:1'b0, tgt:7'h50, cmd:8'h5A, d0:8'h96, d1:8'hC3, chkBlk:0, blk:'0};
    start(3'd0, it);
    rd(3'd0, v); chk("R3 busy", {24'd0, v}, 32'h01);
    wr(3'd2, 8'h44);
    rd(3'd2, v); chk("R5 control unchanged", {24'd0, v}, 0);
    complete(8'h11, 8'h22, '0);
    rd(3'd0, v); chk("R6 done", {24'd0, v}, 32'h02);
    chk("R6 irq", {31'd0, irq}, 1);
    rd(3'd5, v); chk("R7 write keeps data0", {24'd0, v}, 32'h96);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R11 zero keeps done", {24'd0, v}, 32'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); chk("R11 clear done", {24'd0, v}, 0);
    complete(8'h77, 8'h77, '0);
    rd(3'd5, v); chk("R6 idle response ignored", {24'd0, v}, 32'h96);
    rd(3'd0, v); chk("R6 idle no done", {24'd0, v}, 0);

    // R7 byte read
    wr(3'd4, 8'hA1);
    it = '{proto:3'd1, rd:1'b1, tgt:7'h50, cmd:8'h5A, d0:8'h96, d1:8'hC3, chkBlk:0, blk:'0};
    start(3'd1, it);
    complete(8'h3C, 8'h99, '0);
    rd(3'd5, v); chk("R7 byte read data0", {24'd0, v}, 32'h3C);
    rd(3'd6, v); chk("R7 byte read data1", {24'd0, v}, 32'hC3);
    wr(3'd0, 8'h02);

    // R7 byte-data write
    wr(3'd4, 8'h22); wr(3'd3, 8'h12); wr(3'd5, 8'h34);
    it = '{proto:3'd2, rd:1'b0, tgt:7'h11, cmd:8'h12, d0:8'h34, d1:8'hC3, chkBlk:0, blk:'0};
    start(3'd2, it);
    complete(8'hEE, 8'hEE, '0);
    rd(3'd5, v); chk("R7 write data0 kept", {24'd0, v}, 32'h34);
    rd(3'd6, v); chk("R7 write data1 kept", {24'd0, v}, 32'hC3);
    wr(3'd0, 8'h02);

    // R8 word read
    wr(3'd4, 8'h23);
    it = '{proto:3'd3, rd:1'b1, tgt:7'h11, cmd:8'h12, d0:8'h34, d1:8'hC3, chkBlk:0, blk:'0};
    start(3'd3, it);
    complete(8'hCD, 8'hAB, '0);
    rd(3'd5, v); chk("R8 word low", {24'd0, v}, 32'hCD);
    rd(3'd6, v); chk("R8 word high", {24'd0, v}, 32'hAB);
    wr(3'd0, 8'h02);

    // R4 unsupported code
    wr(3'd2, 8'h40 | (8'd4 << 2));
    rd(3'd0, v); chk("R4 error set busy clear", {24'd0, v}, 32'h04);
    wr(3'd2, 8'h40 | (8'd7 << 2));
    rd(3'd0, v); chk("R4 code 7 error", {24'd0, v}, 32'h04);
    wr(3'd0, 8'h04); rd(3'd0, v); chk("R11 clear error", {24'd0, v}, 0);

    // R10 + R12 block write with wrap on the 33rd byte
    for (int i = 0; i < 33; i++) wr(3'd7, 8'(8'h80 + i));
    for (int i = 0; i < 32; i++) blkExp[i*8 +: 8] = 8'(8'h80 + i);
    blkExp[7:0] = 8'hA0;
    wr(3'd4, 8'h30); wr(3'd5, 8'h05);
    it = '{proto:3'd5, rd:1'b0, tgt:7'h18, cmd:8'h12, d0:8'h05, d1:8'hAB, chkBlk:1, blk:blkExp};
    start(3'd5, it);
    complete(8'h00, 8'h00, '0);
    rd(3'd5, v); chk("R12 block write count kept", {24'd0, v}, 32'h05);
    wr(3'd0, 8'h02);

    // R9 block read, R10 index reset and wrap on reads
    wr(3'd7, 8'hFF);
    wr(3'd4, 8'h31);
    for (int i = 0; i < 32; i++) blkRsp[i*8 +: 8] = 8'(8'h10 + i);
    it = '{proto:3'd5, rd:1'b1, tgt:7'h18, cmd:8'h12, d0:8'h05, d1:8'hAB, chkBlk:0, blk:'0};
    start(3'd5, it);
    complete(8'h04, 8'h00, blkRsp);
    rd(3'd5, v); chk("R9 block count", {24'd0, v}, 32'h04);
    rd(3'd7, v); chk("R10 index reset at start", {24'd0, v}, 32'h10);
    rd(3'd7, v); chk("R9 block entry1", {24'd0, v}, 32'h11);
    rd(3'd7, v); chk("R9 block entry2", {24'd0, v}, 32'h12);
    for (int i = 3; i < 31; i++) rd(3'd7, v);
    rd(3'd7, v); chk("R10 last entry", {24'd0, v}, 32'h2F);
    rd(3'd7, v); chk("R10 wrap to entry0", {24'd0, v}, 32'h10);

    repeat (4) @(negedge clk);
    chk("R3 all requests seen", expQ.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule